// File: doc/BRIEF.md
# Configuration monitor interrupt unit

This block watches twelve status signals coming from a programmable-logic configuration port and turns them into one interrupt request for a processor. Each input is first brought into the local clock domain by a synchronizer. It is then judged active either by its level or by a transition, with a per-input choice of which sense counts as active.

Software programs the unit over a small word-addressed register bus. One register holds a global per-bit enable, one holds a per-bit mask, one selects level or edge sensing and one selects the active sense. A write-one-to-clear register retires latched edge events. Three read-only views complete the map: the live synchronized input levels, the raw pending status, and the status left after the enable and mask are applied.

The input bits have fixed roles. Bit 0 is the configuration-error strobe (low while the device reports a fault). Bit 1 is the configuration-complete flag and bit 2 is the initialisation-complete flag. Bit 3 is the checksum error. Bit 4 is the protocol-configuration complete flag. Bits 5 to 7 are ready, error and done for partial reconfiguration. Bits 8, 9 and 10 echo the configuration-request, error and complete pins directly. Bit 11 is the power-good indication.

Top module: `cmi_irq_unit`

## Requirements
- R1: After reset the enable, mask, sense-type and polarity registers read 0, the interrupt output is low and the port register reads 0.
- R2: Word address 0 is enable, 1 is mask, 2 is sense type and 3 is polarity; these read back what was written. Bits at or above position 12 read 0. Address 4 is masked status, 5 is raw status, 6 is clear (write-only, reads 0) and 7 is port. Writes to addresses 4, 5 and 7 change nothing.
- R3: The port register bit i shows input i after passing through two flops: a change appears on the second rising clock edge after it is applied, and not on the first.
- R4: With sense-type bit i at 0 (level), raw status bit i equals input i when polarity bit i is 1 and its inverse when polarity bit i is 0, and follows the input continuously.
- R5: With sense-type bit i at 1 (edge), raw status bit i is set by a synchronized transition into the active sense and stays set after the input returns to the inactive sense.
- R6: Writing to the clear register clears each latched edge bit written as 1 and leaves bits written as 0 unchanged.
- R7: Masked status equals raw status AND enable AND NOT mask, and the interrupt output is high exactly when any masked status bit is 1.
- R8: When the enable register is all zero, the interrupt output stays low and masked status reads 0, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_in | input | 12 | Asynchronous monitor inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |

## Verification
A wrong synchronizer depth shows up on the port register one clock early or late, and the bench probes both the first and the second edge after an input change. A sense or polarity error flips raw status bits within two clocks of an input change. A latched edge bit that is lost or stuck shows up at the next raw-status read after the input returns to idle or after a clear write. Enable and mask faults reach the interrupt pin in the same cycle as the register update, and table vectors that mix the two fields expose them.

// File: rtl/cmi_pkg.sv
package cmi_pkg;
   localparam int CMI_ADDR_W = 3;
   typedef enum logic [CMI_ADDR_W-1:0] {
      RA_ENABLE = 3'd0,
      RA_MASK   = 3'd1,
      RA_SENSE  = 3'd2,
      RA_POLAR  = 3'd3,
      RA_MSTAT  = 3'd4,
      RA_RAW    = 3'd5,
      RA_CLEAR  = 3'd6,
      RA_PORT   = 3'd7
   } cmi_addr_e;
endpackage

// File: rtl/cmi_sync.sv
module cmi_sync #(
   parameter int WIDTH  = 12,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("cmi_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= {stg_q[STAGES-2:0], d};
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cmi_detect.sv
module cmi_detect #(
   parameter int WIDTH = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] sense_edge,
   input  logic [WIDTH-1:0] polar_hi,
   input  logic [WIDTH-1:0] clr,
   output logic [WIDTH-1:0] raw
);
   logic [WIDTH-1:0] prev_q, pend_q, pend_d, hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend_q <= '0;
      end else begin
         prev_q <= cur;
         pend_q <= pend_d;
      end
   end

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         logic act_now, act_prev;
         assign act_now   = polar_hi[i] ? cur[i]    : ~cur[i];
         assign act_prev  = polar_hi[i] ? prev_q[i] : ~prev_q[i];
         assign hit[i]    = act_now & ~act_prev;
         assign pend_d[i] = sense_edge[i] & (hit[i] | (pend_q[i] & ~clr[i]));
         assign raw[i]    = sense_edge[i] ? pend_q[i] : act_now;

         // R5
         edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[i] && !clr[i] && sense_edge[i]) |=> (pend_q[i] || !sense_edge[i]));
         // R6
         edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !hit[i]) |=> !pend_q[i]);
         // R4
         level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !sense_edge[i] |-> (raw[i] == (cur[i] == polar_hi[i])));
      end
   endgenerate
endmodule

// File: rtl/cmi_regs.sv
module cmi_regs
   import cmi_pkg::*;
#(
   parameter int WIDTH  = 12,
   parameter int DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr,
   input  logic [CMI_ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0]     wdata,
   input  logic [WIDTH-1:0]      raw,
   input  logic [WIDTH-1:0]      mstat,
   input  logic [WIDTH-1:0]      port,
   output logic [WIDTH-1:0]      enable_q,
   output logic [WIDTH-1:0]      mask_q,
   output logic [WIDTH-1:0]      sense_q,
   output logic [WIDTH-1:0]      polar_q,
   output logic [WIDTH-1:0]      clr,
   output logic [DATA_W-1:0]     rdata
);
   generate
      if (WIDTH > DATA_W) begin : g_bad
         $error("cmi_regs: more inputs than data bits");
      end
   endgenerate

   logic [WIDTH-1:0] wbits, sel;
   assign wbits = wdata[WIDTH-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= '0;
         mask_q   <= '0;
         sense_q  <= '0;
         polar_q  <= '0;
      end else if (wr) begin
         case (cmi_addr_e'(addr))
            RA_ENABLE: enable_q <= wbits;
            RA_MASK:   mask_q   <= wbits;
            RA_SENSE:  sense_q  <= wbits;
            RA_POLAR:  polar_q  <= wbits;
            default: ;
         endcase
      end
   end

   assign clr = (wr && cmi_addr_e'(addr) == RA_CLEAR) ? wbits : '0;

   always_comb begin
      case (cmi_addr_e'(addr))
         RA_ENABLE: sel = enable_q;
         RA_MASK:   sel = mask_q;
         RA_SENSE:  sel = sense_q;
         RA_POLAR:  sel = polar_q;
         RA_MSTAT:  sel = mstat;
         RA_RAW:    sel = raw;
         RA_PORT:   sel = port;
         default:   sel = '0;
      endcase
   end

   assign rdata = DATA_W'(sel);
endmodule

// File: rtl/cmi_irq_unit.sv
module cmi_irq_unit
   import cmi_pkg::*;
#(
   parameter int NUM_IN      = 12,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_IN-1:0]     mon_in,
   input  logic                  bus_wr,
   input  logic [CMI_ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   output logic                  irq
);
   logic [NUM_IN-1:0] sync_lv, raw, mstat, en, msk, sense, polar, clr;

   cmi_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(mon_in), .q(sync_lv));

   cmi_detect #(.WIDTH(NUM_IN)) u_det (
      .clk(clk), .rst_n(rst_n), .cur(sync_lv), .sense_edge(sense),
      .polar_hi(polar), .clr(clr), .raw(raw));

   cmi_regs #(.WIDTH(NUM_IN), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .raw(raw), .mstat(mstat), .port(sync_lv),
      .enable_q(en), .mask_q(msk), .sense_q(sense), .polar_q(polar),
      .clr(clr), .rdata(bus_rdata));

   assign mstat = raw & en & ~msk;
   assign irq   = |mstat;

   // R7
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((raw & en) != '0));
   // R8
   irq_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> !irq);
endmodule

// File: tb/cmi_irq_unit_test.sv
`timescale 1ns/1ps
module cmi_irq_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] mon_in = '0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int total = 0;
   int bad = 0;
   bit fin = 0;

   always #2.5 clk = ~clk;

   cmi_irq_unit uut (.clk(clk), .rst_n(rst_n), .mon_in(mon_in), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   typedef struct packed {
      logic [11:0] pol;
      logic [11:0] en;
      logic [11:0] msk;
      logic [11:0] din;
   } vec_t;

   localparam vec_t VT [6] = '{
      '{12'hFFF, 12'hFFF, 12'h000, 12'h0F0},
      '{12'h000, 12'hFFF, 12'h000, 12'hFFF},
      '{12'h0F0, 12'h00F, 12'h000, 12'h000},
      '{12'hFFF, 12'hFFF, 12'hFFF, 12'hAAA},
      '{12'h800, 12'h800, 12'h7FF, 12'h800},
      '{12'h555, 12'h000, 12'h000, 12'h555}
   };

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   initial begin
      logic [31:0] v;
      logic [11:0] er;
      settle(3);
      rst_n = 1'b1;
      settle(1);
      // R1 reset state
      rd_reg(3'd0, v); chk("R1 enable", v, 0);
      rd_reg(3'd1, v); chk("R1 mask", v, 0);
      rd_reg(3'd2, v); chk("R1 sense", v, 0);
      rd_reg(3'd3, v); chk("R1 polar", v, 0);
      rd_reg(3'd7, v); chk("R1 port", v, 0);
      chk("R1 irq", {31'd0, irq}, 0);

      // R4 R7 R8 table of level-mode vectors
      for (int k = 0; k < 6; k++) begin
         wr_reg(3'd3, {20'd0, VT[k].pol});
         wr_reg(3'd0, {20'd0, VT[k].en});
         wr_reg(3'd1, {20'd0, VT[k].msk});
         mon_in = VT[k].din;
         settle(3);
         er = ~(VT[k].din ^ VT[k].pol);
         rd_reg(3'd5, v); chk("R4 raw level", v, {20'd0, er});
         rd_reg(3'd4, v); chk("R7 masked", v, {20'd0, er & VT[k].en & ~VT[k].msk});
         chk("R7 R8 irq", {31'd0, irq}, {31'd0, |(er & VT[k].en & ~VT[k].msk)});
      end

      // R2 readback, width limit, read-only and write-only addresses
      wr_reg(3'd0, 32'hFFFF_FFFF);
      rd_reg(3'd0, v); chk("R2 enable width", v, 32'h0000_0FFF);
      wr_reg(3'd2, 32'h0000_0123);
      rd_reg(3'd2, v); chk("R2 sense", v, 32'h123);
      wr_reg(3'd2, 32'h0);
      rd_reg(3'd6, v); chk("R2 clear reads 0", v, 0);
      wr_reg(3'd3, 32'hFFF);
      mon_in = 12'h00F;
      settle(3);
      wr_reg(3'd5, 32'h0);
      wr_reg(3'd7, 32'hFFF);
      wr_reg(3'd4, 32'h0);
      rd_reg(3'd5, v); chk("R2 raw write ignored", v, 32'h00F);
      rd_reg(3'd7, v); chk("R2 port write ignored", v, 32'h00F);

      // R8 enable zero with active inputs
      wr_reg(3'd0, 32'h0);
      wr_reg(3'd1, 32'h0);
      rd_reg(3'd4, v); chk("R8 masked zero", v, 0);
      chk("R8 irq low", {31'd0, irq}, 0);

      // R3 synchronizer depth
      mon_in = 12'hA5C;
      @(negedge clk);
      rd_reg(3'd7, v); chk("R3 port after one edge", v, 32'h00F);
      @(negedge clk);
      rd_reg(3'd7, v); chk("R3 port after two edges", v, 32'hA5C);

      // R5 R6 edge sensing, active high
      mon_in = 12'h000;
      settle(3);
      wr_reg(3'd2, 32'hFFF);
      wr_reg(3'd6, 32'hFFF);
      rd_reg(3'd5, v); chk("R5 edge idle", v, 0);
      mon_in = 12'h008;
      settle(3);
      rd_reg(3'd5, v); chk("R5 rising latched", v, 32'h008);
      mon_in = 12'h000;
      settle(3);
      rd_reg(3'd5, v); chk("R5 held after release", v, 32'h008);
      wr_reg(3'd0, 32'h008);
      chk("R7 edge irq", {31'd0, irq}, 1);
      wr_reg(3'd6, 32'h001);
      rd_reg(3'd5, v); chk("R6 other bit clear keeps", v, 32'h008);
      wr_reg(3'd6, 32'h008);
      rd_reg(3'd5, v); chk("R6 clear", v, 0);
      chk("R6 irq drops", {31'd0, irq}, 0);

      // R5 edge sensing, active low on bit 5
      wr_reg(3'd3, 32'hFDF);
      mon_in = 12'h020;
      settle(3);
      wr_reg(3'd6, 32'hFFF);
      rd_reg(3'd5, v); chk("R5 leaving active no latch", v, 0);
      mon_in = 12'h000;
      settle(3);
      rd_reg(3'd5, v); chk("R5 falling latched", v, 32'h020);

      // R4 return to level mode follows input
      wr_reg(3'd2, 32'h0);
      wr_reg(3'd3, 32'hFFF);
      mon_in = 12'h300;
      settle(3);
      rd_reg(3'd5, v); chk("R4 level follows", v, 32'h300);
      mon_in = 12'h000;
      settle(3);
      rd_reg(3'd5, v); chk("R4 level drops", v, 0);

      fin = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!fin) begin
         total++;
         bad++;
         $display("FAIL R1 watchdog got=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule